// File: doc/BRIEF.md
# DRAM Refresh and Self-Refresh Manager

This block sits on the controller side of a two-bank synchronous DRAM. It keeps the memory's contents alive without help from the rest of the controller. A free-running tick of known period feeds an interval counter. That counter marks one refresh as owed for every slice of the retention window. Owed refreshes collect in a small backlog. Each one is sent as an auto-refresh command as soon as every bank reports idle and the controller is not holding the memory in power-down. After each command the block drives only no-operation cycles for the row-precharge time.

On request, the block also places the memory in low-power retention. It sends the same command encoding with the clock-enable pin low, keeps clock enable low for at least the minimum active-row time, and raises it again only once the caller asks to leave and confirms that the memory clock is running. A busy flag tells the command scheduler to keep its own traffic off the pins. When the backlog fills, a precharge request asks the scheduler to close its open rows so the backlog can drain.

Top module: `rfm_top`

## Requirements
- R1: After reset the pins show a no-operation (ras_n, cas_n and we_n high, dsf low) with cke high, and busy_o and pre_req_o are low.
- R2: One refresh becomes owed for every REF_WINDOW_NS/(REF_COUNT*TICK_NS) pulses of tick_i. With ticks every cycle and all banks idle, at least REF_COUNT auto-refresh commands leave per window.
- R3: An auto-refresh (ras_n low, cas_n low, we_n high, dsf low, cke high) appears only in the cycle after one in which every bit of banks_idle_i was 1 (one bit per bank) and pdown_i was 0. Otherwise owed refreshes wait.
- R4: At least T_RP no-operation cycles follow every command before the next one. While a backlog drains, the gap is exactly T_RP.
- R5: With banks idle and pdown_i low, sr_enter_i produces the auto-refresh encoding with cke low. It wins over a pending auto-refresh and discards the backlog. While cke stays low the pins carry no-operations. sr_enter_i has no effect while a bank is open.
- R6: Once self-refresh is entered, cke stays low for at least T_RAS cycles. With the exit request already present, cke rises after exactly T_RAS cycles.
- R7: cke rises only when sr_exit_i and clk_ok_i were both high in the previous cycle. busy_o then stays high for T_RP cycles before any new command.
- R8: The backlog counts up to MAX_PEND owed refreshes and saturates there. Each counted refresh is issued later.
- R9: pre_req_o is high exactly while the backlog holds MAX_PEND, and busy_o is high whenever pre_req_o is.
- R10: busy_o is high from each command cycle through its T_RP gap, and for the whole of self-refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse every TICK_NS nanoseconds |
| banks_idle_i | input | NUM_BANKS | One bit per bank, 1 when the bank has no open row |
| pdown_i | input | 1 | Controller is holding the memory in power-down |
| sr_enter_i | input | 1 | Request to enter self-refresh |
| sr_exit_i | input | 1 | Request to leave self-refresh |
| clk_ok_i | input | 1 | Memory clock has restarted and is stable |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| dsf_o | output | 1 | Special-function select, low for refresh |
| cke_o | output | 1 | Clock enable |
| busy_o | output | 1 | Command pins are owned by this block or the backlog is full |
| pre_req_o | output | 1 | Request to precharge all open banks |

## Verification
A corrupted backlog count is visible at the ports within about forty cycles. It shows up either as the wrong number of auto-refresh commands once banks go idle, or as pre_req_o at the wrong level. A sequencer that leaves its gap state too early produces a command fewer than T_RP cycles after the previous one. The wrong residency count moves the rising edge of cke away from exactly T_RAS cycles after entry. An interval counter that drifts lowers the number of refreshes counted across ten consecutive windows.

// File: rtl/rfm_pkg.sv
package rfm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GAP  = 2'd1,
        ST_SELF = 2'd2
    } rfm_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic dsf;
        logic cke;
    } rfm_pins_t;

    // no-operation, clock enabled
    localparam rfm_pins_t PINS_NOP  = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, dsf: 1'b0, cke: 1'b1};
    // auto-refresh
    localparam rfm_pins_t PINS_AREF = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, dsf: 1'b0, cke: 1'b1};
    // self-refresh entry
    localparam rfm_pins_t PINS_SREF = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, dsf: 1'b0, cke: 1'b0};
    // no-operation while clock enable is held low
    localparam rfm_pins_t PINS_HOLD = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, dsf: 1'b0, cke: 1'b0};

endpackage

// File: rtl/rfm_interval.sv
module rfm_interval #(
    parameter int unsigned PERIOD = 156
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic due_o
);
    localparam int unsigned CW   = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ivl_t;

    ivl_t ivl_d, ivl_q;
    logic due_d;

    always_comb begin
        ivl_d = ivl_q;
        due_d = 1'b0;
        if (tick_i) begin
            if (ivl_q.cnt == LAST) begin
                ivl_d.cnt = '0;
                due_d     = 1'b1;
            end else begin
                ivl_d.cnt = ivl_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ivl_q <= '0;
        else        ivl_q <= ivl_d;
    end

    assign due_o = due_d;
endmodule

// File: rtl/rfm_backlog.sv
module rfm_backlog #(
    parameter int unsigned MAX_PEND = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc_i,
    input  logic dec_i,
    input  logic clr_i,
    output logic any_o,
    output logic full_o
);
    localparam int unsigned CW  = $clog2(MAX_PEND + 1);
    localparam logic [CW-1:0] TOP = CW'(MAX_PEND);

    typedef struct packed {
        logic [CW-1:0] lvl;
    } blg_t;

    blg_t blg_d, blg_q;
    logic take;

    always_comb begin
        blg_d = blg_q;
        take  = dec_i && (blg_q.lvl != '0);
        if (clr_i) begin
            blg_d.lvl = '0;
        end else begin
            unique case ({inc_i, take})
                2'b10: if (blg_q.lvl != TOP) blg_d.lvl = blg_q.lvl + 1'b1;
                2'b01: blg_d.lvl = blg_q.lvl - 1'b1;
                default: blg_d.lvl = blg_q.lvl;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) blg_q <= '0;
        else        blg_q <= blg_d;
    end

    assign any_o  = (blg_q.lvl != '0);
    assign full_o = (blg_q.lvl == TOP);
endmodule

// File: rtl/rfm_seq.sv
module rfm_seq
    import rfm_pkg::*;
#(
    parameter int unsigned T_RP  = 3,
    parameter int unsigned T_RAS = 6
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      banks_ok_i,
    input  logic      owed_i,
    input  logic      sr_enter_i,
    input  logic      sr_exit_i,
    input  logic      clk_ok_i,
    output rfm_pins_t pins_o,
    output logic      aref_take_o,
    output logic      sref_take_o,
    output logic      active_o
);
    localparam int unsigned MAXT = (T_RP > T_RAS) ? T_RP : T_RAS;
    localparam int unsigned CW   = $clog2(MAXT + 1);
    localparam logic [CW-1:0] GAP_LOAD  = CW'(T_RP);
    localparam logic [CW-1:0] HOLD_LOAD = CW'(T_RAS - 1);

    typedef struct packed {
        rfm_state_e    state;
        logic [CW-1:0] cnt;
        rfm_pins_t     pins;
    } seq_t;

    seq_t seq_d, seq_q;
    logic can_issue;

    always_comb begin
        seq_d       = seq_q;
        aref_take_o = 1'b0;
        sref_take_o = 1'b0;
        // commands need clock enable high in the previous cycle
        can_issue   = banks_ok_i && seq_q.pins.cke;
        unique case (seq_q.state)
            ST_IDLE: begin
                seq_d.pins = PINS_NOP;
                if (sr_enter_i && can_issue) begin
                    seq_d.pins  = PINS_SREF;
                    seq_d.state = ST_SELF;
                    seq_d.cnt   = HOLD_LOAD;
                    sref_take_o = 1'b1;
                end else if (owed_i && can_issue) begin
                    seq_d.pins  = PINS_AREF;
                    seq_d.state = ST_GAP;
                    seq_d.cnt   = GAP_LOAD;
                    aref_take_o = 1'b1;
                end
            end
            ST_GAP: begin
                seq_d.pins = PINS_NOP;
                seq_d.cnt  = seq_q.cnt - 1'b1;
                if (seq_q.cnt <= CW'(1)) begin
                    seq_d.state = ST_IDLE;
                    seq_d.cnt   = '0;
                end
            end
            ST_SELF: begin
                seq_d.pins = PINS_HOLD;
                if (seq_q.cnt != '0) begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end else if (sr_exit_i && clk_ok_i) begin
                    seq_d.pins  = PINS_NOP;
                    seq_d.state = ST_GAP;
                    seq_d.cnt   = GAP_LOAD;
                end
            end
            default: begin
                seq_d.pins  = PINS_NOP;
                seq_d.state = ST_IDLE;
                seq_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.state <= ST_IDLE;
            seq_q.cnt   <= '0;
            seq_q.pins  <= PINS_NOP;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign pins_o   = seq_q.pins;
    assign active_o = (seq_q.state != ST_IDLE);
endmodule

// File: rtl/rfm_top.sv
module rfm_top
    import rfm_pkg::*;
#(
    parameter int unsigned NUM_BANKS     = 2,
    parameter int unsigned TICK_NS       = 100,
    parameter int unsigned REF_WINDOW_NS = 32_000_000,
    parameter int unsigned REF_COUNT     = 2048,
    parameter int unsigned T_RP          = 3,
    parameter int unsigned T_RAS         = 6,
    parameter int unsigned MAX_PEND      = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic [NUM_BANKS-1:0] banks_idle_i,
    input  logic                 pdown_i,
    input  logic                 sr_enter_i,
    input  logic                 sr_exit_i,
    input  logic                 clk_ok_i,
    output logic                 ras_n_o,
    output logic                 cas_n_o,
    output logic                 we_n_o,
    output logic                 dsf_o,
    output logic                 cke_o,
    output logic                 busy_o,
    output logic                 pre_req_o
);
    localparam int unsigned RAW_PERIOD    = REF_WINDOW_NS / (REF_COUNT * TICK_NS);
    localparam int unsigned TICKS_PER_REF = (RAW_PERIOD < 1) ? 1 : RAW_PERIOD;

    logic      due, owed, full, banks_ok;
    logic      aref_take, sref_take, active;
    logic      all_idle;
    rfm_pins_t pins;

    // reduce per-bank idle bits
    logic [NUM_BANKS:0] idle_chain;
    assign idle_chain[0] = 1'b1;
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign idle_chain[b+1] = idle_chain[b] & banks_idle_i[b];
    end
    assign all_idle = idle_chain[NUM_BANKS];
    assign banks_ok = all_idle && !pdown_i;

    rfm_interval #(.PERIOD(TICKS_PER_REF)) u_interval (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_i(tick_i),
        .due_o (due)
    );

    rfm_backlog #(.MAX_PEND(MAX_PEND)) u_backlog (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (due),
        .dec_i (aref_take),
        .clr_i (sref_take),
        .any_o (owed),
        .full_o(full)
    );

    rfm_seq #(.T_RP(T_RP), .T_RAS(T_RAS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .banks_ok_i (banks_ok),
        .owed_i     (owed),
        .sr_enter_i (sr_enter_i),
        .sr_exit_i  (sr_exit_i),
        .clk_ok_i   (clk_ok_i),
        .pins_o     (pins),
        .aref_take_o(aref_take),
        .sref_take_o(sref_take),
        .active_o   (active)
    );

    assign ras_n_o   = pins.ras_n;
    assign cas_n_o   = pins.cas_n;
    assign we_n_o    = pins.we_n;
    assign dsf_o     = pins.dsf;
    assign cke_o     = pins.cke;
    assign pre_req_o = full;
    assign busy_o    = active || full;
endmodule

// File: rtl/rfm_checker.sv
module rfm_checker #(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned T_RP      = 3,
    parameter int unsigned T_RAS     = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_BANKS-1:0] banks_idle_i,
    input logic                 pdown_i,
    input logic                 sr_exit_i,
    input logic                 clk_ok_i,
    input logic                 ras_n_o,
    input logic                 cas_n_o,
    input logic                 we_n_o,
    input logic                 dsf_o,
    input logic                 cke_o,
    input logic                 busy_o,
    input logic                 pre_req_o
);
    localparam int unsigned GW = $clog2(T_RP + 2);
    localparam int unsigned LW = $clog2(T_RAS + 2);

    logic [GW-1:0] gap_q;
    logic [LW-1:0] low_q;

    // NOP cycles since the last command, saturating at T_RP
    always_ff @(posedge clk) begin
        if (!rst_n)                   gap_q <= GW'(T_RP);
        else if (!ras_n_o)            gap_q <= '0;
        else if (gap_q < GW'(T_RP))   gap_q <= gap_q + 1'b1;
    end

    // cycles spent with clock enable low, saturating above T_RAS
    always_ff @(posedge clk) begin
        if (!rst_n)                    low_q <= '0;
        else if (cke_o)                low_q <= '0;
        else if (low_q <= LW'(T_RAS))  low_q <= low_q + 1'b1;
    end

    p_aref_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n_o && cke_o) |-> $past((&banks_idle_i) && !pdown_i));

    p_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n_o |-> (gap_q >= GW'(T_RP)));

    p_enter_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke_o) |-> (!ras_n_o && !cas_n_o && we_n_o && !dsf_o));

    p_hold_nop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_o && $past(!cke_o)) |-> (ras_n_o && cas_n_o && we_n_o));

    p_residency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke_o) |-> (low_q >= LW'(T_RAS)));

    p_exit_cond_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke_o) |-> $past(sr_exit_i && clk_ok_i));

    p_pre_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pre_req_o |-> busy_o);

    p_self_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_o |-> busy_o);
endmodule

bind rfm_top rfm_checker #(
    .NUM_BANKS(NUM_BANKS),
    .T_RP     (T_RP),
    .T_RAS    (T_RAS)
) u_rfm_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .banks_idle_i(banks_idle_i),
    .pdown_i     (pdown_i),
    .sr_exit_i   (sr_exit_i),
    .clk_ok_i    (clk_ok_i),
    .ras_n_o     (ras_n_o),
    .cas_n_o     (cas_n_o),
    .we_n_o      (we_n_o),
    .dsf_o       (dsf_o),
    .cke_o       (cke_o),
    .busy_o      (busy_o),
    .pre_req_o   (pre_req_o)
);

// File: tb/tb_rfm_top.sv
`timescale 1ns/1ps
module tb_rfm_top;
    localparam int T_RP      = 3;
    localparam int T_RAS     = 6;
    localparam int MAX_PEND  = 4;
    localparam int REF_COUNT = 16;
    localparam int TICK_NS   = 100;
    localparam int PER       = 4;
    localparam int WINDOW_NS = REF_COUNT * PER * TICK_NS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_i = 1'b0;
    logic [1:0] banks_idle_i = 2'b11;
    logic pdown_i = 1'b0;
    logic sr_enter_i = 1'b0;
    logic sr_exit_i = 1'b0;
    logic clk_ok_i = 1'b0;
    logic ras_n_o, cas_n_o, we_n_o, dsf_o, cke_o, busy_o, pre_req_o;

    int errors = 0;
    int checks = 0;
    int aref_cnt = 0;
    int gap_viol = 0;
    int last_gap = -1;
    int gap_run = 0;
    bit seen_cmd = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rfm_top #(
        .NUM_BANKS(2), .TICK_NS(TICK_NS), .REF_WINDOW_NS(WINDOW_NS),
        .REF_COUNT(REF_COUNT), .T_RP(T_RP), .T_RAS(T_RAS), .MAX_PEND(MAX_PEND)
    ) dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .banks_idle_i(banks_idle_i),
        .pdown_i(pdown_i), .sr_enter_i(sr_enter_i), .sr_exit_i(sr_exit_i),
        .clk_ok_i(clk_ok_i), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
        .dsf_o(dsf_o), .cke_o(cke_o), .busy_o(busy_o), .pre_req_o(pre_req_o)
    );

    // pin monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (!ras_n_o) begin
                if (seen_cmd) begin
                    last_gap = gap_run;
                    if (gap_run < T_RP) gap_viol++;
                end
                seen_cmd = 1'b1;
                gap_run  = 0;
                if (cke_o && !cas_n_o && we_n_o && !dsf_o) aref_cnt++;
            end else begin
                gap_run++;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_ge(input string req, input int act, input int lim);
        checks++;
        if (act < lim) begin
            errors++;
            $display("FAIL %s actual=%0d expected>=%0d", req, act, lim);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic pulse_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
        end
    endtask

    // {banks_idle[1:0], pdown, ticks[7:0], exp_arefs[3:0], exp_pre_req}
    localparam logic [15:0] VEC [7] = '{
        {2'b11, 1'b0, 8'd4,  4'd1, 1'b0},  // R2 R3 one interval, idle
        {2'b01, 1'b0, 8'd8,  4'd0, 1'b0},  // R3 bank open, two owed
        {2'b11, 1'b0, 8'd0,  4'd2, 1'b0},  // R8 postponed pair drains
        {2'b11, 1'b1, 8'd12, 4'd0, 1'b0},  // R3 power-down blocks, three owed
        {2'b10, 1'b0, 8'd4,  4'd0, 1'b1},  // R9 backlog reaches limit
        {2'b10, 1'b0, 8'd8,  4'd0, 1'b1},  // R8 saturation
        {2'b11, 1'b0, 8'd0,  4'd4, 1'b0}   // R8 R4 limit drains
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        int base;
        int lowc;
        int busyc;
        int waitc;

        // R1 reset state
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        check("R1 cke", int'(cke_o), 1);
        check("R1 nop", int'({ras_n_o, cas_n_o, we_n_o, dsf_o}), 4'b1110);
        check("R1 busy", int'(busy_o), 0);
        check("R1 pre_req", int'(pre_req_o), 0);

        // table of backlog scenarios
        for (int v = 0; v < 7; v++) begin
            banks_idle_i = VEC[v][15:14];
            pdown_i      = VEC[v][13];
            base         = aref_cnt;
            pulse_ticks(int'(VEC[v][12:5]));
            cycles(40);
            check($sformatf("R3 R8 vec%0d arefs", v), aref_cnt - base, int'(VEC[v][4:1]));
            check($sformatf("R9 vec%0d pre_req", v), int'(pre_req_o), int'(VEC[v][0]));
            check($sformatf("R10 vec%0d busy", v), int'(busy_o), int'(VEC[v][0]));
        end
        check("R4 drain gap exact", last_gap, T_RP);

        // R10 busy across a single refresh
        base = aref_cnt;
        pulse_ticks(PER);
        busyc = 0;
        for (int i = 0; i < 20; i++) begin
            cycles(1);
            if (busy_o) busyc++;
        end
        check("R10 busy length", busyc, T_RP);
        check("R2 single owed", aref_cnt - base, 1);

        // R5 entry refused with a bank open
        banks_idle_i = 2'b01;
        sr_enter_i   = 1'b1;
        cycles(10);
        check("R5 refused open bank", int'(cke_o), 1);
        sr_enter_i   = 1'b0;

        // R5 R7 entry, then exit held off by clock not ready
        banks_idle_i = 2'b11;
        clk_ok_i     = 1'b0;
        sr_exit_i    = 1'b1;
        @(negedge clk); sr_enter_i = 1'b1;
        waitc = 0;
        cycles(1);
        while (cke_o && waitc < 20) begin cycles(1); waitc++; end
        check("R5 entry cke", int'(cke_o), 0);
        check("R5 entry code", int'({ras_n_o, cas_n_o, we_n_o, dsf_o}), 4'b0010);
        sr_enter_i = 1'b0;
        cycles(20);
        check("R7 no exit without clock", int'(cke_o), 0);
        check("R10 busy in self-refresh", int'(busy_o), 1);
        check("R5 nop while held", int'({ras_n_o, cas_n_o, we_n_o}), 3'b111);
        clk_ok_i = 1'b1;
        cycles(3);
        check("R7 exit with clock", int'(cke_o), 1);
        cycles(10);

        // R5 priority and backlog clear; R6 exact residency; R7 gap after exit
        banks_idle_i = 2'b10;
        pulse_ticks(2 * PER);
        base = aref_cnt;
        @(negedge clk);
        banks_idle_i = 2'b11;
        sr_enter_i   = 1'b1;
        waitc = 0;
        cycles(1);
        while (cke_o && waitc < 20) begin cycles(1); waitc++; end
        sr_enter_i = 1'b0;
        lowc = 0;
        while (!cke_o && lowc < 100) begin lowc++; cycles(1); end
        check("R6 residency exact", lowc, T_RAS);
        busyc = 0;
        while (busy_o && busyc < 50) begin busyc++; cycles(1); end
        check("R7 busy after exit", busyc, T_RP);
        cycles(30);
        check("R5 backlog discarded", aref_cnt - base, 0);
        sr_exit_i = 1'b0;

        // R2 sustained rate over ten windows
        base = aref_cnt;
        @(negedge clk); tick_i = 1'b1;
        cycles(10 * REF_COUNT * PER);
        tick_i = 1'b0;
        cycles(20);
        check_ge("R2 window rate", aref_cnt - base, 10 * REF_COUNT - 1);

        check("R4 no short gap", gap_viol, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule